// File: doc/BRIEF.md
# Phased SPI Transaction Master

This block is an SPI bus master that carries out one complete transaction per request. A transaction is described by a descriptor that is presented on parallel inputs and latched when the request is taken. The descriptor holds a command word and its bit length, an address word and its bit length, up to 32 bits of write data and its length, a dummy-cycle count, a read length, a duplex mode and a device select. The block drives the serial clock, the serial output and three active-low chip selects. It samples the serial input and returns up to 32 received bits together with a one-cycle completion pulse.

The transaction is a fixed sequence of phases: command, address, write, dummy, read. Every phase whose length is zero is skipped. In half-duplex mode the write bits go out first and the read bits are taken afterwards. In full-duplex mode the write phase also samples the bus, and the dummy and read phases do not run. Only single-bit transfers are supported. The serial clock is the system clock divided by `CLK_DIV` (4 by default), using SPI mode 0. Data is sent MSB first.

The control state machine has six states:
- `ST_IDLE`: waiting. An accepted request moves it to `ST_SETUP`.
- `ST_SETUP`: chip select is low and the first bit is presented for one half period. If no phase is live it then goes to `ST_DONE`; otherwise it goes to `ST_HIGH`.
- `ST_HIGH`: serial clock high. At its end it goes to `ST_LOW`, or to `ST_HOLD` after the last bit.
- `ST_LOW`: serial clock low. It then returns to `ST_HIGH`.
- `ST_HOLD`: one settling half period with the clock low. It then goes to `ST_DONE`.
- `ST_DONE`: chip select released and the completion pulse raised. It then returns to `ST_IDLE`.

Top module: `spi_phase_master`

## Requirements
- R1: Phases run in the order command, address, write, dummy, read. A phase of length zero produces no clock edges. The number of rising serial-clock edges equals the sum of the live phase lengths.
- R2: The command length is 0 to 16 bits and the address length is 0 to 64 bits. Each field is right-aligned in its input, so bit (length-1) is sent first and bit 0 is sent last. No input bits are stored during these phases.
- R3: Mode 0 timing applies. The serial clock idles low and each level lasts CLK_DIV/2 system clocks. The output bit changes only while the clock is low and never during a high level. The input is sampled at the rising edge.
- R4: In full-duplex mode the bus carries command + address + write-length bits, whatever the dummy and read lengths are. The first min(read length, write length) bits sampled during the write phase are stored.
- R5: In half-duplex mode the write bits are sent, then the dummy cycles, then read-length clocks. Only bits sampled in the read phase are stored.
- R6: The dummy phase gives dummy-length clocks with the output held at 0 and nothing stored.
- R7: Device select values 0, 1 and 2 drive low only cs_n[0], cs_n[1] or cs_n[2]. The value 3 drives none. The chosen select stays low without a break for 4×N+2 system clocks, where N is the bus bit count.
- R8: rd_data holds the stored bits right-aligned. The last stored bit is at bit 0 and unused upper bits are 0. The value is valid when done is high.
- R9: A request is taken only while busy is low, and busy rises in the next cycle. A request raised during a transaction is ignored: it does not change the running transaction and does not start another one. The descriptor inputs may change after acceptance without effect.
- R10: done is high for exactly one cycle. That cycle is the first one in which all chip selects are high again.
- R11: When every live phase length is zero, the chip select is low for one half period (2 clocks) with no clock edge, and then done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start request, taken while busy is low |
| busy | output | 1 | High from acceptance until done |
| cmd_len | input | 5 | Command bit count, 0..16 |
| cmd | input | 16 | Command word, right-aligned |
| addr_len | input | 7 | Address bit count, 0..64 |
| addr | input | 64 | Address word, right-aligned |
| wr_len | input | 6 | Write bit count, 0..32 |
| wr_data | input | 32 | Write data, right-aligned |
| dummy_len | input | 8 | Dummy clock count |
| rd_len | input | 6 | Read bit count, 0..32 |
| full_duplex | input | 1 | 1 merges the write and read phases |
| dev_sel | input | 2 | Device select 0..2; 3 selects none |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low chip selects |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Received bits |

## Verification
Directed descriptors cover the following cases:
- An all-zero transaction, which separates the settle-only path from a real clocked one.
- Maximum command, address and write lengths, which expose bit-order and index slicing errors.
- Full-duplex runs with the read length both above and below the write length, which separate capping of the stored bits from bus extension.
- A dummy-only transaction and a half-duplex read-only transaction, which show whether dummy cycles are stored by mistake.
- Device select 3, and a request raised in mid-transaction, which isolate chip-select decode and acceptance gating.

Random descriptors from a fixed seed then mix all lengths, modes and devices. For each run the bench compares the serial bit stream, the rising-edge count, the chip-select window length and the returned word against values computed from the descriptor and from a random input pattern.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;
    typedef enum logic [2:0] {
        PH_CMD  = 3'd0,
        PH_ADDR = 3'd1,
        PH_WR   = 3'd2,
        PH_DUM  = 3'd3,
        PH_RD   = 3'd4,
        PH_NONE = 3'd5
    } phase_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_DONE
    } state_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int CW   = (HALF < 2) ? 1 : $clog2(HALF);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NUM_CS = 3,
    parameter int SEL_W  = 2
) (
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(active && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
    import spi_phase_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int CMD_W    = 16,
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 32,
    parameter int DUMMY_LW = 8,
    parameter int NUM_CS   = 3,
    localparam int CMD_LW  = $clog2(CMD_W + 1),
    localparam int ADDR_LW = $clog2(ADDR_W + 1),
    localparam int DATA_LW = $clog2(DATA_W + 1),
    localparam int SEL_W   = $clog2(NUM_CS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    output logic                busy,
    input  logic [CMD_LW-1:0]   cmd_len,
    input  logic [CMD_W-1:0]    cmd,
    input  logic [ADDR_LW-1:0]  addr_len,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_LW-1:0]  wr_len,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DUMMY_LW-1:0] dummy_len,
    input  logic [DATA_LW-1:0]  rd_len,
    input  logic                full_duplex,
    input  logic [SEL_W-1:0]    dev_sel,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int LW  = (ADDR_LW > DUMMY_LW) ? ADDR_LW : DUMMY_LW;
    localparam int CIW = $clog2(CMD_W);
    localparam int AIW = $clog2(ADDR_W);
    localparam int DIW = $clog2(DATA_W);

    state_t state, state_nx;
    phase_t ph, ph_first, ph_after;
    logic [LW-1:0] idx;

    logic [CMD_W-1:0]    q_cmd;
    logic [ADDR_W-1:0]   q_addr;
    logic [DATA_W-1:0]   q_wdata;
    logic [CMD_LW-1:0]   q_cmd_len;
    logic [ADDR_LW-1:0]  q_addr_len;
    logic [DATA_LW-1:0]  q_wr_len, q_rd_len, cnt;
    logic [DUMMY_LW-1:0] q_dum_len;
    logic                q_fd;
    logic [SEL_W-1:0]    q_sel;
    logic [DATA_W-1:0]   rx;

    logic [LW-1:0] l_cmd, l_addr, l_wr, l_dum, l_rd;
    logic [4:0]    live;
    logic          tick, cs_active, rise, cap_en, fd_cur;

    function automatic phase_t pick_after(input int p, input logic [4:0] lv);
        phase_t r = PH_NONE;
        for (int i = 4; i >= 0; i--) begin
            if (i > p && lv[i]) r = phase_t'(3'(i));
        end
        return r;
    endfunction

    function automatic logic [LW-1:0] len_sel(input phase_t p,
        input logic [LW-1:0] c, a, w, d, r);
        unique case (p)
            PH_CMD:  return c;
            PH_ADDR: return a;
            PH_WR:   return w;
            PH_DUM:  return d;
            PH_RD:   return r;
            default: return '0;
        endcase
    endfunction

    // Lengths come from the ports while idle, from the latched copy otherwise.
    always_comb begin
        if (state == ST_IDLE) begin
            l_cmd  = LW'(cmd_len);   l_addr = LW'(addr_len);
            l_wr   = LW'(wr_len);    l_dum  = LW'(dummy_len);
            l_rd   = LW'(rd_len);    fd_cur = full_duplex;
        end else begin
            l_cmd  = LW'(q_cmd_len); l_addr = LW'(q_addr_len);
            l_wr   = LW'(q_wr_len);  l_dum  = LW'(q_dum_len);
            l_rd   = LW'(q_rd_len);  fd_cur = q_fd;
        end
        live     = {!fd_cur && l_rd != '0, !fd_cur && l_dum != '0,
                    l_wr != '0, l_addr != '0, l_cmd != '0};
        ph_first = pick_after(-1, live);
        ph_after = pick_after(int'(ph), live);
    end

    spi_half_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .tick(tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = ST_SETUP;
            ST_SETUP: if (tick) state_nx = (ph == PH_NONE) ? ST_DONE : ST_HIGH;
            ST_HIGH:  if (tick) state_nx = (idx == '0 && ph_after == PH_NONE) ? ST_HOLD : ST_LOW;
            ST_LOW:   if (tick) state_nx = ST_HIGH;
            ST_HOLD:  if (tick) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign rise   = tick && (state == ST_SETUP || state == ST_LOW) && ph != PH_NONE;
    assign cap_en = (ph == PH_RD) || (q_fd && ph == PH_WR);

    // Descriptor latch, phase/bit position and receive shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= PH_NONE; idx <= '0; rx <= '0; cnt <= '0;
            q_cmd <= '0; q_addr <= '0; q_wdata <= '0; q_cmd_len <= '0;
            q_addr_len <= '0; q_wr_len <= '0; q_rd_len <= '0; q_dum_len <= '0;
            q_fd <= 1'b0; q_sel <= '0;
        end else if (state == ST_IDLE) begin
            if (req) begin
                q_cmd <= cmd; q_addr <= addr; q_wdata <= wr_data;
                q_cmd_len <= cmd_len; q_addr_len <= addr_len;
                q_wr_len <= wr_len; q_rd_len <= rd_len; q_dum_len <= dummy_len;
                q_fd <= full_duplex; q_sel <= dev_sel;
                ph  <= ph_first;
                idx <= len_sel(ph_first, l_cmd, l_addr, l_wr, l_dum, l_rd) - 1'b1;
                rx  <= '0;
                cnt <= '0;
            end
        end else begin
            if (rise && cap_en && cnt < q_rd_len) begin
                rx  <= {rx[DATA_W-2:0], miso};
                cnt <= cnt + 1'b1;
            end
            if (state == ST_HIGH && tick) begin
                if (idx != '0) begin
                    idx <= idx - 1'b1;
                end else begin
                    ph  <= ph_after;
                    idx <= len_sel(ph_after, l_cmd, l_addr, l_wr, l_dum, l_rd) - 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        sclk      = (state == ST_HIGH);
        cs_active = (state == ST_SETUP) || (state == ST_HIGH) ||
                    (state == ST_LOW) || (state == ST_HOLD);
        unique case (ph)
            PH_CMD:  mosi = q_cmd[idx[CIW-1:0]];
            PH_ADDR: mosi = q_addr[idx[AIW-1:0]];
            PH_WR:   mosi = q_wdata[idx[DIW-1:0]];
            default: mosi = 1'b0;
        endcase
        if (!cs_active) mosi = 1'b0;
        rd_data = rx;
    end

    spi_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
        .active(cs_active), .sel(q_sel), .cs_n(cs_n)
    );

    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n));
    a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && (&cs_n)));
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> busy);
endmodule

// File: tb/spi_phase_master_tb_top.sv
module spi_phase_master_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
    logic busy, sclk, mosi, done;
    logic miso = 1'b0;
    logic [4:0] cmd_len = '0;
    logic [15:0] cmd = '0;
    logic [6:0] addr_len = '0;
    logic [63:0] addr = '0;
    logic [5:0] wr_len = '0, rd_len = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [7:0] dummy_len = '0;
    logic full_duplex = 1'b0;
    logic [1:0] dev_sel = '0;
    logic [2:0] cs_n;

    int n_checks = 0, n_errs = 0, cyc = 0;

    spi_phase_master dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .busy(busy),
        .cmd_len(cmd_len), .cmd(cmd), .addr_len(addr_len), .addr(addr),
        .wr_len(wr_len), .wr_data(wr_data), .dummy_len(dummy_len),
        .rd_len(rd_len), .full_duplex(full_duplex), .dev_sel(dev_sel),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .done(done), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bus monitor / slave model, sampled on the falling system clock edge
    bit mon_on = 1'b0;
    int nrise = 0, cs_low_cyc = 0, mosi_bad = 0;
    logic [2:0] cs_seen = '0;
    logic [511:0] got = '0, mpat = '0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (sclk && !prev_sclk) begin got[nrise] = mosi; nrise++; end
            if (sclk && prev_sclk && mosi !== prev_mosi) mosi_bad++;
            if (cs_n != 3'b111) cs_low_cyc++;
            cs_seen |= ~cs_n;
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
        miso = mpat[nrise];
        if (cyc > 190000) begin
            n_errs++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic run(input int cl, input logic [15:0] c, input int al, input logic [63:0] a,
                       input int wl, input logic [31:0] wd, input int dl, input int rl,
                       input bit fd, input int ds, input bit poke);
        logic [511:0] exp_bits = '0;
        logic [31:0] erd = '0;
        int n = 0, start, ncap, wait_cyc = 0, bad = 0;
        for (int i = 0; i < 16; i++) mpat[i*32 +: 32] = $urandom;
        for (int i = cl - 1; i >= 0; i--) begin exp_bits[n] = c[i]; n++; end
        for (int i = al - 1; i >= 0; i--) begin exp_bits[n] = a[i]; n++; end
        for (int i = wl - 1; i >= 0; i--) begin exp_bits[n] = wd[i]; n++; end
        if (!fd) n = n + dl + rl;
        start = fd ? cl + al : cl + al + wl + dl;
        ncap  = fd ? min2(rl, wl) : rl;
        for (int k = 0; k < ncap; k++) erd = {erd[30:0], mpat[start + k]};

        @(negedge clk);
        nrise = 0; cs_low_cyc = 0; mosi_bad = 0; cs_seen = '0; got = '0;
        miso = mpat[0];
        mon_on = 1'b1;
        cmd_len = 5'(cl); cmd = c; addr_len = 7'(al); addr = a;
        wr_len = 6'(wl); wr_data = wd; dummy_len = 8'(dl); rd_len = 6'(rl);
        full_duplex = fd; dev_sel = 2'(ds);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy === 1'b1, "R9 busy after accept", busy, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            cmd = ~c; wr_data = ~wd; rd_len = 6'd0; dev_sel = 2'd3; req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        while (!done && wait_cyc < 5000) begin @(negedge clk); wait_cyc++; end
        chk(done === 1'b1, "R10 done seen", done, 1);
        chk(cs_n === 3'b111, "R10 selects high at done", cs_n, 3'b111);
        chk(rd_data === erd, "R8/R4/R5 read data", rd_data, erd);
        chk(nrise == n, "R1 rising edge count", nrise, n);
        for (int i = 0; i < n; i++) if (got[i] !== exp_bits[i]) bad++;
        chk(bad == 0, "R2/R6 serial stream bits wrong", bad, 0);
        chk(mosi_bad == 0, "R3 mosi changed while sclk high", mosi_bad, 0);
        chk(cs_low_cyc == ((ds < 3) ? 4 * n + 2 : 0), "R7/R3/R11 select window",
            cs_low_cyc, (ds < 3) ? 4 * n + 2 : 0);
        chk(cs_seen === ((ds < 3) ? 3'(1 << ds) : 3'b000), "R7 which select",
            cs_seen, (ds < 3) ? (1 << ds) : 0);
        mon_on = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 done one cycle", {done, busy}, 0);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(busy === 1'b0 && cs_n === 3'b111 && sclk === 1'b0,
                "R9 ignored request started nothing", {busy, cs_n, sclk}, 8'h0e);
        end
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R9 reset busy/done", {busy, done}, 0);
        chk(cs_n === 3'b111 && sclk === 1'b0, "R7 reset bus idle", {cs_n, sclk}, 4'he);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 empty transaction
        run(0, 16'h0, 0, 64'h0, 0, 32'h0, 0, 0, 1'b0, 0, 1'b0);
        // R11 full duplex with only dummy/read lengths: nothing live
        run(0, 16'h0, 0, 64'h0, 0, 32'h0, 5, 7, 1'b1, 1, 1'b0);
        // R2 maximum lengths
        run(16, 16'hA5C3, 64, 64'hF00D_1234_5678_9ABC, 32, 32'hDEAD_BEEF, 3, 32, 1'b0, 2, 1'b0);
        // R4 full duplex, read longer and shorter than write
        run(8, 16'h9F, 24, 64'h12_3456, 12, 32'hABC, 4, 20, 1'b1, 0, 1'b0);
        run(0, 16'h0, 0, 64'h0, 32, 32'h8000_0001, 0, 5, 1'b1, 1, 1'b0);
        // R5 half duplex read only, R6 dummy only
        run(0, 16'h0, 0, 64'h0, 0, 32'h0, 0, 17, 1'b0, 2, 1'b0);
        run(0, 16'h0, 0, 64'h0, 0, 32'h0, 9, 0, 1'b0, 0, 1'b0);
        // R7 no device selected
        run(4, 16'hB, 8, 64'h5A, 4, 32'h6, 2, 4, 1'b0, 3, 1'b0);
        // R9 request during transaction
        run(8, 16'h3C, 16, 64'hBEEF, 8, 32'h81, 2, 8, 1'b0, 1, 1'b1);
        for (int t = 0; t < 40; t++) begin
            run($urandom_range(0, 16), 16'($urandom), $urandom_range(0, 64),
                {$urandom, $urandom}, $urandom_range(0, 32), $urandom,
                $urandom_range(0, 8), $urandom_range(0, 32), 1'($urandom),
                $urandom_range(0, 3), 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule